// File: doc/BRIEF.md
# Per-Pad Peripheral Pin Multiplexer

This block sits between a row of pad cells and the peripheral functions that share them. Each pad has its own selection register. The code in that register picks one of the pad's function slots. The chosen slot drives the pad output and the pad output-enable, and it receives the pad's input. Every function slot that is not selected sees a constant zero on its input.

A code that names no slot leaves the pad as a plain input and delivers its value to no one. Software reaches the selection registers through a small strobe-style register port. Writes keep only the low selection bits, and reads return the value zero-extended to the data width. An index with no register behind it reports an error.

Top module: `pad_func_mux`

## Requirements
- R1: After reset every selection register reads 0, so each pad is routed to its function slot 0.
- R2: The slot kind is fixed by position. Slot 0 is bidirectional: the pad takes the slot's output and output-enable. Slot 1 is output-only: the pad takes the slot's output, with output-enable forced to 1. Slot 2 is input-only: the pad output and output-enable are both 0.
- R3: The pad input reaches the input of the selected slot only when that slot is bidirectional or input-only. All other slot inputs of that pad are 0.
- R4: A selection code of N_FUNCS or more (code 3 by default) drives pad output 0 and output-enable 0, and sets every slot input of that pad to 0.
- R5: The register index is address bits [IDX_HI:IDX_LO], which are [4:2] by default. All other address bits are ignored.
- R6: A write stores the low SEL_W bits of the write data. The new routing appears only after the next rising clock edge.
- R7: A read returns the addressed selection value zero-extended to DATA_W, in the same cycle as the request.
- R8: An access whose index is N_PADS or more sets the error flag. Such a write changes no register, and such a read returns 0.
- R9: An access to a mapped index returns error 0.
- R10: While the valid strobe is low, the error flag and the read data are 0 and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Access address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data |
| bus_err_o | output | 1 | Error / write status (1 = unmapped) |
| pad_in_i | input | N_PADS | Value sensed at each pad |
| pad_out_o | output | N_PADS | Value driven to each pad |
| pad_oe_o | output | N_PADS | Pad output-enable |
| fn_out_i | input | N_PADS*N_FUNCS | Slot outputs, bit p*N_FUNCS+f |
| fn_oe_i | input | N_PADS*N_FUNCS | Slot output-enables, same indexing |
| fn_in_o | output | N_PADS*N_FUNCS | Slot inputs, same indexing |

## Verification
Some rules are checked by assertions on every cycle:
- each pad feeds at most one slot input;
- an out-of-range code silences the pad;
- a mapped write lands one edge later with the truncated value;
- unmapped writes leave all selections unchanged;
- an idle port returns zero.

Only the bench scenarios show the rest: the slot-kind behaviour of output and output-enable, the aliasing of the ignored address bits, and the fact that routing holds its old value until the write's clock edge. They compare every pad and slot against a reference model under random selections and random pad and slot values.

// File: rtl/pad_func_mux_pkg.sv
package pad_func_mux_pkg;
  typedef enum logic [1:0] {
    FK_BIDIR = 2'd0,
    FK_OUT   = 2'd1,
    FK_IN    = 2'd2
  } fn_kind_e;
endpackage

// File: rtl/pad_func_mux_regs.sv
module pad_func_mux_regs #(
  parameter int N_PADS = 4,
  parameter int SEL_W  = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IDX_LO = 2,
  parameter int IDX_HI = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bus_valid_i,
  input  logic                    bus_write_i,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic [DATA_W-1:0]       bus_wdata_i,
  output logic [DATA_W-1:0]       bus_rdata_o,
  output logic                    bus_err_o,
  output logic [N_PADS*SEL_W-1:0] sel_o
);
  localparam int IDX_W = IDX_HI - IDX_LO + 1;

  logic [IDX_W-1:0] idx;
  logic             hit;
  logic [SEL_W-1:0] sel_q [N_PADS];

  assign idx = bus_addr_i[IDX_HI:IDX_LO];
  assign hit = (32'(idx) < N_PADS);
  assign bus_err_o = bus_valid_i && !hit;

  for (genvar p = 0; p < N_PADS; p++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        sel_q[p] <= '0;
      else if (bus_valid_i && bus_write_i && idx == IDX_W'(p))
        sel_q[p] <= bus_wdata_i[SEL_W-1:0];
    end
    assign sel_o[p*SEL_W +: SEL_W] = sel_q[p];

    assert_wr_take_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_valid_i && bus_write_i && idx == IDX_W'(p))
        |=> sel_q[p] == $past(bus_wdata_i[SEL_W-1:0]));
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_valid_i && !bus_write_i)
      for (int p = 0; p < N_PADS; p++)
        if (idx == IDX_W'(p)) bus_rdata_o = DATA_W'(sel_q[p]);
  end

  assert_unmapped_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_write_i && bus_err_o) |=> $stable(sel_o));
  assert_unmapped_rd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !bus_write_i && bus_err_o) |-> bus_rdata_o == '0);
  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_valid_i |=> $stable(sel_o));
  assert_idle_out_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_valid_i |-> (!bus_err_o && bus_rdata_o == '0));
endmodule

// File: rtl/pad_func_mux_route.sv
module pad_func_mux_route
  import pad_func_mux_pkg::*;
#(
  parameter int                   N_FUNCS  = 3,
  parameter int                   SEL_W    = 2,
  parameter logic [2*N_FUNCS-1:0] KIND_MAP = 6'b10_01_00
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               pad_in_i,
  output logic               pad_out_o,
  output logic               pad_oe_o,
  input  logic [N_FUNCS-1:0] fn_out_i,
  input  logic [N_FUNCS-1:0] fn_oe_i,
  output logic [N_FUNCS-1:0] fn_in_o
);
  always_comb begin
    pad_out_o = 1'b0;
    pad_oe_o  = 1'b0;
    fn_in_o   = '0;
    for (int f = 0; f < N_FUNCS; f++) begin
      if (32'(sel_i) == f) begin
        case (fn_kind_e'(KIND_MAP[2*f +: 2]))
          FK_BIDIR: begin
            pad_out_o  = fn_out_i[f];
            pad_oe_o   = fn_oe_i[f];
            fn_in_o[f] = pad_in_i;
          end
          FK_OUT: begin
            pad_out_o = fn_out_i[f];
            pad_oe_o  = 1'b1;
          end
          default: fn_in_o[f] = pad_in_i;
        endcase
      end
    end
  end

  assert_one_sink_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fn_in_o));
  assert_idle_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(sel_i) >= N_FUNCS) |-> (!pad_out_o && !pad_oe_o && fn_in_o == '0));
endmodule

// File: rtl/pad_func_mux.sv
module pad_func_mux #(
  parameter int                   N_PADS   = 4,
  parameter int                   N_FUNCS  = 3,
  parameter int                   SEL_W    = 2,
  parameter int                   ADDR_W   = 8,
  parameter int                   DATA_W   = 32,
  parameter int                   IDX_LO   = 2,
  parameter int                   IDX_HI   = 4,
  parameter logic [2*N_FUNCS-1:0] KIND_MAP = 6'b10_01_00
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bus_valid_i,
  input  logic                      bus_write_i,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  input  logic [DATA_W-1:0]         bus_wdata_i,
  output logic [DATA_W-1:0]         bus_rdata_o,
  output logic                      bus_err_o,
  input  logic [N_PADS-1:0]         pad_in_i,
  output logic [N_PADS-1:0]         pad_out_o,
  output logic [N_PADS-1:0]         pad_oe_o,
  input  logic [N_PADS*N_FUNCS-1:0] fn_out_i,
  input  logic [N_PADS*N_FUNCS-1:0] fn_oe_i,
  output logic [N_PADS*N_FUNCS-1:0] fn_in_o
);
  logic [N_PADS*SEL_W-1:0] sel;

  pad_func_mux_regs #(
    .N_PADS(N_PADS), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .IDX_LO(IDX_LO), .IDX_HI(IDX_HI)
  ) regs_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .bus_err_o(bus_err_o),
    .sel_o(sel)
  );

  for (genvar p = 0; p < N_PADS; p++) begin : g_pad
    pad_func_mux_route #(
      .N_FUNCS(N_FUNCS), .SEL_W(SEL_W), .KIND_MAP(KIND_MAP)
    ) route_i (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .sel_i(sel[p*SEL_W +: SEL_W]),
      .pad_in_i(pad_in_i[p]),
      .pad_out_o(pad_out_o[p]),
      .pad_oe_o(pad_oe_o[p]),
      .fn_out_i(fn_out_i[p*N_FUNCS +: N_FUNCS]),
      .fn_oe_i(fn_oe_i[p*N_FUNCS +: N_FUNCS]),
      .fn_in_o(fn_in_o[p*N_FUNCS +: N_FUNCS])
    );
  end
endmodule

// File: tb/pad_func_mux_tb_top.sv
`timescale 1ns/1ps
module pad_func_mux_tb_top;
  localparam int NP = 4, NF = 3, SW = 2, AW = 8, DW = 32;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic bus_err;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
  logic [NP*NF-1:0] fn_out = '0, fn_oe = '0, fn_in;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [SW-1:0] sel_m [NP];

  always #4 clk = ~clk;

  pad_func_mux dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .bus_err_o(bus_err),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .fn_out_i(fn_out), .fn_oe_i(fn_oe), .fn_in_o(fn_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int idx_of(input logic [AW-1:0] a);
    return int'(a[4:2]);
  endfunction

  // slot kinds: 0 bidir, 1 output-only, 2 input-only
  function automatic logic [NP-1:0] exp_out();
    logic [NP-1:0] r = '0;
    for (int p = 0; p < NP; p++)
      if (sel_m[p] == 0 || sel_m[p] == 1) r[p] = fn_out[p*NF + int'(sel_m[p])];
    return r;
  endfunction

  function automatic logic [NP-1:0] exp_oe();
    logic [NP-1:0] r = '0;
    for (int p = 0; p < NP; p++) begin
      if (sel_m[p] == 0) r[p] = fn_oe[p*NF];
      else if (sel_m[p] == 1) r[p] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [NP*NF-1:0] exp_in();
    logic [NP*NF-1:0] r = '0;
    for (int p = 0; p < NP; p++)
      if (sel_m[p] == 0 || sel_m[p] == 2) r[p*NF + int'(sel_m[p])] = pad_in[p];
    return r;
  endfunction

  task automatic check_route(input string tag);
    chk(pad_out == exp_out(), {tag, " R2 pad_out"}, DW'(pad_out), DW'(exp_out()));
    chk(pad_oe == exp_oe(), {tag, " R2/R4 pad_oe"}, DW'(pad_oe), DW'(exp_oe()));
    chk(fn_in == exp_in(), {tag, " R3/R4 fn_in"}, DW'(fn_in), DW'(exp_in()));
  endtask

  task automatic rand_pins();
    @(negedge clk);
    pad_in = NP'($urandom);
    fn_out = (NP*NF)'($urandom);
    fn_oe = (NP*NF)'($urandom);
    #1;
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    int i = idx_of(a);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    #1;
    chk(bus_err == (i >= NP), {tag, " R8/R9 wr err"}, DW'(bus_err), DW'(i >= NP));
    check_route({tag, " R6 before edge"});
    @(posedge clk);
    if (i < NP) sel_m[i] = d[SW-1:0];
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    #1;
    check_route({tag, " R6 after edge"});
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, input string tag);
    int i = idx_of(a);
    logic [DW-1:0] e;
    e = (i < NP) ? DW'(sel_m[i]) : '0;
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1;
    chk(bus_err == (i >= NP), {tag, " R8/R9 rd err"}, DW'(bus_err), DW'(i >= NP));
    chk(bus_rdata == e, {tag, " R7/R8 rdata"}, bus_rdata, e);
    @(negedge clk);
    bus_valid = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int p = 0; p < NP; p++) sel_m[p] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1 reset state
    for (int p = 0; p < NP; p++) bus_rd(AW'(p * 4), "R1 reset read");
    rand_pins();
    check_route("R1 reset route");
    // R4 out-of-range code on pad 2
    bus_wr(8'h08, 32'h3, "R4 code3");
    rand_pins();
    check_route("R4 code3 pins");
    // R6 truncation: 0xFFFFFFF5 -> 1 on pad 1
    bus_wr(8'h04, 32'hFFFF_FFF5, "R6 trunc");
    bus_rd(8'h04, "R6 trunc read");
    // R5 alias: high and low address bits ignored (0xE3 -> index 0)
    bus_wr(8'hE3, 32'h2, "R5 alias");
    bus_rd(8'h01, "R5 alias read");
    // R8 unmapped write index 5
    bus_wr(8'h14, 32'h1, "R8 unmapped wr");
    for (int p = 0; p < NP; p++) bus_rd(AW'(p * 4), "R8 regs kept");
    bus_rd(8'h1C, "R8 unmapped rd");
    // R10 idle strobe
    @(negedge clk);
    bus_valid = 0; bus_write = 1; bus_addr = 8'h00; bus_wdata = 32'h3;
    #1;
    chk(bus_err == 0 && bus_rdata == 0, "R10 idle outputs", {bus_rdata[DW-2:0], bus_err}, '0);
    @(negedge clk);
    bus_write = 0;
    bus_rd(8'h00, "R10 no write");
    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      if ($urandom_range(0, 1) == 1) bus_wr(a, $urandom, "rand");
      else bus_rd(a, "rand");
      rand_pins();
      check_route("rand pins");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule